// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block turns the fast module clock into the serial clock of an SPI master. A control word selects one of two division laws. The linear law gives half-periods of N+1 module clocks. The power-of-two law gives half-periods of 2^M module clocks. The serial clock therefore runs at the module clock divided by 2*(N+1) or by 2^(M+1), always with 50% duty. Beside the serial clock level, the block emits one-cycle strobes on the leading and the trailing edge, which a shift engine uses to drive and sample data.

The generator runs only while `run_i` is high; one high stretch of `run_i` is a burst. At the first cycle of a burst it captures the control word and the clock polarity. It ignores both inputs until the next burst, so software may rewrite them at any time without disturbing a transfer in progress. While idle, the serial clock rests at the polarity level and the half-period counter is cleared.

Top module: `spi_clk_div`

## Requirements
- R1: While the generator is idle, `sclk_o` equals `cpol_i` (it follows `cpol_i` combinationally) and neither strobe is asserted.
- R2: With `ctl_i[12]` = 1 (linear law), every half-period of `sclk_o` lasts `ctl_i[7:0]`+1 module clocks.
- R3: With `ctl_i[12]` = 0 (power-of-two law), every half-period of `sclk_o` lasts 2^`ctl_i[11:8]` module clocks.
- R4: If `run_i` is first sampled high at clock edge k, `sclk_o` holds the captured polarity level until edge k+H, where it first toggles (H is the half-period). It toggles again at every H edges after that.
- R5: `lead_o` is high for exactly the one cycle in which `sclk_o` has just left the polarity level. `trail_o` is high for exactly the cycle in which it has just returned to that level. Each strobe coincides with a change of `sclk_o`, and the two strobes are never high together.
- R6: Changes to `ctl_i` or `cpol_i` while `run_i` stays high have no effect on `sclk_o` or the strobes until the next burst.
- R7: When `run_i` is sampled low, `sclk_o` returns to `cpol_i` at that edge without a strobe. The next burst starts with a cleared counter, so its timing is the same as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High for the duration of a burst |
| ctl_i | input | 13 | Control word: [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on the leading edge |
| trail_o | output | 1 | One-cycle strobe on the trailing edge |

## Verification
The bench uses the default widths: an 8-bit linear field and a 4-bit exponent. The half-period therefore spans from 1 to 32768 module clocks. Directed bursts reach both ends of each law (N=0, N=255, M=0, M=15). Random bursts cover the middle, some with the control word and polarity rewritten mid-burst. One burst is aborted partway through a half-period and then restarted, which checks that the counter is cleared.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;
endpackage

// File: rtl/spi_div_cfg_latch.sv
module spi_div_cfg_latch
  import spi_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int HP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [LIN_W+POW_W:0]     ctl,
  input  logic                     cpol,
  output logic [HP_W-1:0]          lim,
  output logic                     cpol_q
);
  localparam int SEL_BIT = LIN_W + POW_W;

  div_law_e          law;
  logic [LIN_W-1:0]  lin_n;
  logic [POW_W-1:0]  pow_m;
  logic [HP_W-1:0]   lim_next;

  always_comb begin
    law   = div_law_e'(ctl[SEL_BIT]);
    lin_n = ctl[LIN_W-1:0];
    pow_m = ctl[SEL_BIT-1:LIN_W];
    if (law == LAW_LINEAR) lim_next = HP_W'(lin_n);
    else                   lim_next = (HP_W'(1) << pow_m) - HP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim    <= '0;
      cpol_q <= 1'b0;
    end else if (load) begin
      lim    <= lim_next;
      cpol_q <= cpol;
    end
  end
endmodule

// File: rtl/spi_div_half_counter.sv
module spi_div_half_counter #(
  parameter int HP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [HP_W-1:0] lim,
  output logic            tick
);
  logic [HP_W-1:0] cnt;

  assign tick = go && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!go)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + HP_W'(1);
  end
endmodule

// File: rtl/spi_div_phase_gen.sv
module spi_div_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic tick,
  output logic phase,
  output logic lead,
  output logic trail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (!go) begin
      phase <= 1'b0;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else begin
      lead  <= tick && !phase;
      trail <= tick && phase;
      if (tick) phase <= ~phase;
    end
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic [LIN_W+POW_W:0]   ctl_i,
  input  logic                   cpol_i,
  output logic                   sclk_o,
  output logic                   lead_o,
  output logic                   trail_o
);
  localparam int POW_SPAN = 1 << POW_W;
  localparam int HP_W     = ((LIN_W + 1) > POW_SPAN) ? (LIN_W + 1) : POW_SPAN;

  logic            active_q;
  logic            load;
  logic            go;
  logic            tick;
  logic            phase;
  logic            cpol_q;
  logic [HP_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= run_i;
  end

  assign load = run_i && !active_q;
  assign go   = run_i && active_q;

  spi_div_cfg_latch #(.LIN_W(LIN_W), .POW_W(POW_W), .HP_W(HP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .ctl(ctl_i), .cpol(cpol_i),
    .lim(lim), .cpol_q(cpol_q)
  );

  spi_div_half_counter #(.HP_W(HP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .go(go), .lim(lim), .tick(tick)
  );

  spi_div_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .go(run_i), .tick(tick),
    .phase(phase), .lead(lead_o), .trail(trail_o)
  );

  assign sclk_o = active_q ? (cpol_q ^ phase) : cpol_i;
endmodule

// File: rtl/spi_clk_div_checker.sv
module spi_clk_div_checker (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o
);
  // R1 / R7: after run_i is sampled low the clock rests at cpol_i, no strobes
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (sclk_o == cpol_i) && !lead_o && !trail_o);

  // R5: strobes are mutually exclusive
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_o, trail_o}));

  // R5: a leading strobe marks a change of the serial clock
  a_r5_lead_moves: assert property (@(posedge clk) disable iff (!rst_n)
    lead_o |-> !$stable(sclk_o));

  // R5: a trailing strobe marks a change of the serial clock
  a_r5_trail_moves: assert property (@(posedge clk) disable iff (!rst_n)
    trail_o |-> !$stable(sclk_o));

  // R5: strobes alternate, a trailing strobe never directly follows a trailing one
  a_r5_no_double_trail: assert property (@(posedge clk) disable iff (!rst_n)
    trail_o |=> !trail_o);
endmodule

bind spi_clk_div spi_clk_div_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .cpol_i(cpol_i),
  .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
);

// File: tb/tb_spi_clk_div.sv
`timescale 1ns/1ps
module tb_spi_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [12:0] ctl_i = '0;
  logic        cpol_i = 1'b0;
  logic        sclk_o, lead_o, trail_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_clk_div dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ctl_i(ctl_i), .cpol_i(cpol_i),
    .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  function automatic int half_of(logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    return 1 << c[11:8];
  endfunction

  function automatic logic [12:0] mk(bit lin, int n, int m);
    logic [12:0] c;
    c = '0;
    c[12] = lin;
    c[7:0] = 8'(n);
    c[11:8] = 4'(m);
    return c;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One burst; stop_n negedges are observed after run_i rises.
  task automatic burst(logic [12:0] c, bit pol, int stop_n, bit scramble, string req);
    int h;
    h = half_of(c);
    @(negedge clk);
    ctl_i = c;
    cpol_i = pol;
    run_i = 1'b1;
    for (int n = 1; n <= stop_n; n++) begin
      int k;
      bit exp_s, exp_l, exp_t, edge_n;
      @(negedge clk);
      if (scramble && n == 2) begin
        ctl_i = 13'($urandom);
        cpol_i = ~pol;
      end
      k = (n - 1) / h;
      exp_s = pol ^ k[0];
      edge_n = (n > 1) && ((n - 1) % h == 0);
      exp_l = edge_n && k[0];
      exp_t = edge_n && !k[0];
      check(sclk_o == exp_s && lead_o == exp_l && trail_o == exp_t,
            req, "sclk/lead/trail", {sclk_o, lead_o, trail_o}, {exp_s, exp_l, exp_t});
    end
    run_i = 1'b0;
    @(negedge clk);
    check(sclk_o == cpol_i && !lead_o && !trail_o, "R7", "stop to idle",
          {sclk_o, lead_o, trail_o}, {cpol_i, 2'b00});
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle follows cpol_i, no strobes
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cpol_i = i[0];
      ctl_i = 13'($urandom);
      #1;
      check(sclk_o == cpol_i && !lead_o && !trail_o, "R1", "idle level",
            {sclk_o, lead_o, trail_o}, {cpol_i, 2'b00});
    end
    // R2 linear corners, R3 power-of-two corners, R4 start latency inside burst
    burst(mk(1, 0, 9), 1'b0, 8 * 1 + 1, 1'b0, "R2");
    burst(mk(1, 255, 0), 1'b1, 4 * 256 + 1, 1'b0, "R2");
    burst(mk(0, 5, 0), 1'b1, 6 * 1 + 1, 1'b0, "R3");
    burst(mk(0, 0, 15), 1'b0, 2 * 32768 + 1, 1'b0, "R3");
    // R6: rewrite ctl and cpol mid-burst
    burst(mk(1, 6, 2), 1'b0, 5 * 7 + 1, 1'b1, "R6");
    burst(mk(0, 3, 3), 1'b1, 5 * 8 + 1, 1'b1, "R6");
    // R7: abort mid half-period, then restart with fresh timing (R4)
    burst(mk(1, 7, 0), 1'b0, 8 + 3, 1'b0, "R7");
    burst(mk(1, 7, 0), 1'b0, 4 * 8 + 1, 1'b0, "R4");
    // random bursts, R5 strobes checked every cycle
    for (int r = 0; r < 16; r++) begin
      logic [12:0] c;
      int hv;
      c = mk($urandom % 2, $urandom % 256, $urandom % 8);
      hv = half_of(c);
      burst(c, 1'($urandom), (2 + $urandom % 4) * hv + 1, 1'($urandom), "R5");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule